// File: doc/BRIEF.md
# 8x8 Multi-Mode Integer and Fractional Multiplier

This block multiplies two 8-bit operands and returns the 16-bit product split into a high byte and a low byte. It also returns a carry flag and a zero flag. A 3-bit mode input selects how the operands are read: both unsigned, both two's complement, or a signed multiplicand times an unsigned multiplier. Each of these three readings also has a fixed-point fractional form. In that form the operands are 1.7 fractions and the product is shifted left by one bit, which gives a 1.15 result.

The unit is a two-stage pipeline. The first stage registers the operands after sign extension, which depends on the mode. The second stage forms the product, applies the fractional shift and registers the result and flags. A valid strobe travels with each operation, so a new pair of operands can be accepted on every clock. The outputs keep the last result until the next one issues. Register-file writeback and instruction decoding are done elsewhere.

Top module: `mul8_unit`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `outValid`, `prodHi`, `prodLo`, `cFlag` and `zFlag` are all 0.
- R2: An operation accepted with `inValid` high at clock edge k gives `outValid` high for exactly one cycle, after edge k+2. Operations accepted on consecutive edges come out on consecutive cycles, and `outValid` is never high otherwise.
- R3: `mode[1:0]` = 0 reads both operands as unsigned. The code 3 behaves exactly like 0.
- R4: `mode[1:0]` = 1 reads both `opA` and `opB` as two's complement.
- R5: `mode[1:0]` = 2 reads `opA` as two's complement and `opB` as unsigned.
- R6: With `mode[2]` = 1, the result is the 16-bit raw product of the selected reading shifted left by one bit, so `prodLo[0]` is 0. With `mode[2]` = 0, the result is the raw product. The result appears as {`prodHi`,`prodLo`}.
- R7: `cFlag` equals bit 15 of the raw product before any fractional shift.
- R8: `zFlag` is 1 exactly when the delivered 16-bit result {`prodHi`,`prodLo`} is zero.
- R9: In any cycle where `outValid` is low, `prodHi`, `prodLo`, `cFlag` and `zFlag` keep the values they had in the previous cycle. Operands presented with `inValid` low leave them unchanged.
- R10: For every 8-bit A, multiply A by A in mode 0, then add A and 41 byte-wise with carry into the high byte. The 16-bit sum equals A*A + A + 41.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Operands and mode are valid this cycle |
| mode | input | 3 | [1:0] operand reading (0 unsigned, 1 signed, 2 signed-by-unsigned, 3 as 0); [2] fractional |
| opA | input | 8 | Multiplicand |
| opB | input | 8 | Multiplier |
| outValid | output | 1 | Result issued this cycle |
| prodHi | output | 8 | Result bits 15..8 |
| prodLo | output | 8 | Result bits 7..0 |
| cFlag | output | 1 | Bit 15 of the unshifted product |
| zFlag | output | 1 | Result is zero |

## Verification
The hardest case to reach from the ports is a dense, irregular stream. In it the mode changes on every accepted operation while gaps of invalid cycles, carrying garbage operands, fall between them. Only such a stream shows whether the fractional flag and the sign readings stay aligned with their own operands through both stages, and whether idle cycles truly leave the outputs alone. The stimulus reaches this with a long random run in which the valid density, the mode and the operands are all chosen at random. Directed extremes are added to it: -128 times -128 in the fractional signed form, -128 times 255 in the mixed form, zero operands and the reserved code. A full back-to-back sweep of all 256 inputs for the polynomial check follows.

// File: rtl/mul8_pkg.sv
package mul8_pkg;

  localparam int MODE_W = 3;

  typedef enum logic [1:0] {
    KIND_UU  = 2'd0,
    KIND_SS  = 2'd1,
    KIND_SU  = 2'd2,
    KIND_RSV = 2'd3
  } mulKind_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic capOps;     // register operands (stage 1)
    logic capProd;    // register product and flags (stage 2)
    logic aSigned;    // sign-extend multiplicand
    logic bSigned;    // sign-extend multiplier
    logic fracShift;  // apply 1-bit left shift in stage 2
  } mulStrobe_t;

endpackage

// File: rtl/mul8_ctrl.sv
module mul8_ctrl
  import mul8_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic [MODE_W-1:0] mode,
  output mulStrobe_t        strobe,
  output logic              outValid
);

  mulKind_e kind;
  logic     stage1Valid;
  logic     stage1Frac;

  assign kind = mulKind_e'(mode[1:0]);

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1Valid <= 1'b0;
      stage1Frac  <= 1'b0;
      outValid    <= 1'b0;
    end else begin
      stage1Valid <= inValid;
      outValid    <= stage1Valid;
      if (inValid) begin
        stage1Frac <= mode[MODE_W-1];
      end
    end
  end

  always_comb begin
    strobe.capOps    = inValid;
    strobe.capProd   = stage1Valid;
    strobe.aSigned   = (kind == KIND_SS) || (kind == KIND_SU);
    strobe.bSigned   = (kind == KIND_SS);
    strobe.fracShift = stage1Frac;
  end

endmodule

// File: rtl/mul8_datapath.sv
module mul8_datapath
  import mul8_pkg::*;
#(
  parameter int OP_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  mulStrobe_t      strobe,
  input  logic [OP_W-1:0] opA,
  input  logic [OP_W-1:0] opB,
  output logic [OP_W-1:0] prodHi,
  output logic [OP_W-1:0] prodLo,
  output logic            cFlag,
  output logic            zFlag
);

  localparam int EXT_W  = OP_W + 1;
  localparam int PROD_W = 2 * OP_W;
  localparam int PAD_W  = PROD_W - EXT_W;

  logic [EXT_W-1:0]  aExt, bExt;
  logic [PROD_W-1:0] aWide, bWide;
  logic [PROD_W-1:0] rawProd;
  logic [PROD_W-1:0] result;

  // Stage 1: operands with mode-dependent extension bit
  always_ff @(posedge clk) begin
    if (rst) begin
      aExt <= '0;
      bExt <= '0;
    end else if (strobe.capOps) begin
      aExt <= {strobe.aSigned & opA[OP_W-1], opA};
      bExt <= {strobe.bSigned & opB[OP_W-1], opB};
    end
  end

  // Low PROD_W bits of a product of sign-extended values are exact
  always_comb begin
    aWide   = {{PAD_W{aExt[EXT_W-1]}}, aExt};
    bWide   = {{PAD_W{bExt[EXT_W-1]}}, bExt};
    rawProd = aWide * bWide;
    result  = strobe.fracShift ? {rawProd[PROD_W-2:0], 1'b0} : rawProd;
  end

  // Stage 2: result and flags
  always_ff @(posedge clk) begin
    if (rst) begin
      prodHi <= '0;
      prodLo <= '0;
      cFlag  <= 1'b0;
      zFlag  <= 1'b0;
    end else if (strobe.capProd) begin
      prodHi <= result[PROD_W-1:OP_W];
      prodLo <= result[OP_W-1:0];
      cFlag  <= rawProd[PROD_W-1];
      zFlag  <= (result == '0);
    end
  end

endmodule

// File: rtl/mul8_unit.sv
module mul8_unit
  import mul8_pkg::*;
#(
  parameter int OP_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic [MODE_W-1:0] mode,
  input  logic [OP_W-1:0]   opA,
  input  logic [OP_W-1:0]   opB,
  output logic              outValid,
  output logic [OP_W-1:0]   prodHi,
  output logic [OP_W-1:0]   prodLo,
  output logic              cFlag,
  output logic              zFlag
);

  mulStrobe_t strobe;

  mul8_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .mode     (mode),
    .strobe   (strobe),
    .outValid (outValid)
  );

  mul8_datapath #(.OP_W(OP_W)) u_dp (
    .clk    (clk),
    .rst    (rst),
    .strobe (strobe),
    .opA    (opA),
    .opB    (opB),
    .prodHi (prodHi),
    .prodLo (prodLo),
    .cFlag  (cFlag),
    .zFlag  (zFlag)
  );

endmodule

// File: rtl/mul8_unit_chk.sv
module mul8_unit_chk
  import mul8_pkg::*;
#(
  parameter int OP_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              inValid,
  input logic [MODE_W-1:0] mode,
  input logic [OP_W-1:0]   opA,
  input logic [OP_W-1:0]   opB,
  input logic              outValid,
  input logic [OP_W-1:0]   prodHi,
  input logic [OP_W-1:0]   prodLo,
  input logic              cFlag,
  input logic              zFlag
);

  logic [1:0] sinceRst;

  always_ff @(posedge clk) begin
    if (rst) sinceRst <= 2'd0;
    else if (sinceRst != 2'd3) sinceRst <= sinceRst + 2'd1;
  end

  // R1
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (!outValid && prodHi == '0 && prodLo == '0 && !cFlag && !zFlag));

  // R2
  a_r2_valid_issues: assert property (@(posedge clk) disable iff (rst)
    (sinceRst >= 2'd2 && $past(inValid, 2)) |-> outValid);

  a_r2_valid_only_issued: assert property (@(posedge clk) disable iff (rst)
    (sinceRst >= 2'd2 && outValid) |-> $past(inValid, 2));

  a_r2_valid_quiet_early: assert property (@(posedge clk) disable iff (rst)
    (sinceRst < 2'd2) |-> !outValid);

  // R6
  a_r6_frac_lsb: assert property (@(posedge clk) disable iff (rst)
    (sinceRst >= 2'd2 && outValid && $past(mode[MODE_W-1], 2)) |-> !prodLo[0]);

  // R8
  a_r8_zero_flag: assert property (@(posedge clk) disable iff (rst)
    outValid |-> (zFlag == ({prodHi, prodLo} == '0)));

  // R9
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    (sinceRst >= 2'd1 && !outValid) |-> $stable({prodHi, prodLo, cFlag, zFlag}));

endmodule

bind mul8_unit mul8_unit_chk #(.OP_W(OP_W)) u_chk (.*);

// File: tb/tb_mul8_unit.sv
`timescale 1ns/1ps
module tb_mul8_unit;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       inValid = 1'b0;
  logic [2:0] mode = 3'd0;
  logic [7:0] opA = 8'd0;
  logic [7:0] opB = 8'd0;
  logic       outValid;
  logic [7:0] prodHi, prodLo;
  logic       cFlag, zFlag;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  mul8_unit dut (
    .clk(clk), .rst(rst), .inValid(inValid), .mode(mode),
    .opA(opA), .opB(opB), .outValid(outValid),
    .prodHi(prodHi), .prodLo(prodLo), .cFlag(cFlag), .zFlag(zFlag)
  );

  // Reference model state
  bit         p1V;
  logic [7:0] p1A, p1B;
  logic [2:0] p1M;
  bit         p1Poly;
  bit         expV;
  logic [15:0] expRes;
  logic       expC, expZ;
  logic [7:0] expA;
  logic [2:0] expM;
  bit         expPoly;

  function automatic logic [17:0] refMul(input logic [7:0] a, input logic [7:0] b,
                                         input logic [2:0] m);
    int sa, sb, p;
    logic [15:0] raw, res;
    sa = int'(a);
    sb = int'(b);
    if ((m[1:0] == 2'd1 || m[1:0] == 2'd2) && a[7]) sa = sa - 256;
    if (m[1:0] == 2'd1 && b[7]) sb = sb - 256;
    p   = sa * sb;
    raw = p[15:0];
    res = m[2] ? {raw[14:0], 1'b0} : raw;
    return {raw[15], (res == 16'd0), res};
  endfunction

  function automatic string tagOf(input logic [2:0] m);
    if (m[2]) return "R6";
    if (m[1:0] == 2'd1) return "R4";
    if (m[1:0] == 2'd2) return "R5";
    return "R3";
  endfunction

  task automatic check(input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  task automatic compareOutputs();
    logic [17:0] r;
    logic [8:0]  s;
    logic [7:0]  hi;
    logic [15:0] poly;
    check("R2", "outValid", outValid, expV);
    if (expV) begin
      check(tagOf(expM), "product", {prodHi, prodLo}, expRes);
      check("R7", "cFlag", cFlag, expC);
      check("R8", "zFlag", zFlag, expZ);
      if (expPoly) begin
        s  = {1'b0, prodLo} + {1'b0, expA};
        hi = prodHi + {7'd0, s[8]};
        s  = {1'b0, s[7:0]} + 9'd41;
        hi = hi + {7'd0, s[8]};
        poly = 16'(int'(expA) * int'(expA) + int'(expA) + 41);
        check("R10", "polynomial", {hi, s[7:0]}, poly);
      end
    end else begin
      check("R9", "held result", {prodHi, prodLo}, expRes);
      check("R9", "held flags", {cFlag, zFlag}, {expC, expZ});
    end
    r = 18'd0;
    if (r != 18'd0) $display("unreachable");
  endtask

  // One clock: drive at negedge, model edge, check after edge
  task automatic step(input bit v, input logic [7:0] a, input logic [7:0] b,
                      input logic [2:0] m, input bit poly);
    logic [17:0] r;
    @(negedge clk);
    inValid = v; opA = a; opB = b; mode = m;
    @(posedge clk);
    #1;
    expV = p1V;
    if (p1V) begin
      r       = refMul(p1A, p1B, p1M);
      expC    = r[17];
      expZ    = r[16];
      expRes  = r[15:0];
      expA    = p1A;
      expM    = p1M;
      expPoly = p1Poly;
    end
    p1V = v; p1A = a; p1B = b; p1M = m; p1Poly = poly;
    compareOutputs();
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    p1V = 0; p1A = 0; p1B = 0; p1M = 0; p1Poly = 0;
    expV = 0; expRes = 0; expC = 0; expZ = 0; expA = 0; expM = 0; expPoly = 0;
    repeat (4) @(posedge clk);
    #1;
    check("R1", "outValid in reset", outValid, 0);
    check("R1", "outputs in reset", {prodHi, prodLo, cFlag, zFlag}, 0);
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk);
    #1;
    check("R1", "outValid after reset", outValid, 0);
    check("R1", "outputs after reset", {prodHi, prodLo, cFlag, zFlag}, 0);

    // Directed corners, back to back with changing modes
    step(1, 8'hFF, 8'hFF, 3'd0, 0);   // R3 max unsigned, C=1
    step(1, 8'h80, 8'h80, 3'd1, 0);   // R4 -128*-128
    step(1, 8'h80, 8'h80, 3'd5, 0);   // R6 fractional signed -> 0x8000
    step(1, 8'h80, 8'hFF, 3'd2, 0);   // R5 -128*255
    step(1, 8'hFF, 8'h80, 3'd2, 0);   // R5 -1*128
    step(1, 8'hFF, 8'hFF, 3'd3, 0);   // R3 reserved code acts unsigned
    step(1, 8'h00, 8'h7B, 3'd4, 0);   // R8 zero in fractional
    step(1, 8'h40, 8'h40, 3'd4, 0);   // R6 0.5*0.5 style unsigned frac
    step(1, 8'hC0, 8'h40, 3'd6, 0);   // R6 mixed fractional
    step(1, 8'h7F, 8'h81, 3'd1, 0);   // R4 127*-127
    // Gap with garbage operands: R9
    step(0, 8'h12, 8'h34, 3'd1, 0);
    step(0, 8'hAA, 8'h55, 3'd6, 0);
    step(0, 8'h00, 8'h00, 3'd0, 0);
    step(0, 8'hFF, 8'h01, 3'd7, 0);
    step(1, 8'h03, 8'h05, 3'd0, 0);
    step(0, 8'h99, 8'h99, 3'd5, 0);
    step(0, 8'h77, 8'h66, 3'd2, 0);

    // Random dense and sparse traffic
    for (int i = 0; i < 3000; i++) begin
      step(($urandom_range(0, 3) != 0), 8'($urandom), 8'($urandom),
           3'($urandom), 0);
    end

    // R10 polynomial sweep, back to back
    for (int a = 0; a < 256; a++) begin
      step(1, 8'(a), 8'(a), 3'd0, 1);
    end
    repeat (4) step(0, 8'h00, 8'h00, 3'd0, 0);

    summary();
  end

endmodule